// File: doc/BRIEF.md
# Frame-Transfer CCD Readout Sequencer

This block produces the transfer and shift strobes for a frame-transfer image sensor with an imaging section, a storage (framestore) section and a serial output register split into two halves. Each half shifts toward its own output node. A run begins with a start pulse. Runs then repeat, one frame or one row group at a time, until a stop request is taken at the next boundary. The mode and the geometry (rows, columns, subarray skip count, row-sum count) are latched in a one-cycle load step at the start of every frame or group. Changes on those inputs in mid-run therefore wait for the next boundary.

Three modes are provided:

- **Timed exposure:** a frame marker, then a full-frame move of the imaging section into the storage section. Next come optional skip shifts, which dump the leading storage rows unread into the serial register. The remaining rows are then read in groups: each group is summed by several storage shifts and read out with one serial burst.
- **Continuous:** imaging and storage shift together for one group of rows, and that group is then read out.
- **Flush:** only the imaging section is clocked. This collapses its charge into the first row and so clears it.

Each serial burst is preceded by a fixed number of idle cycles and a row marker. Every serial shift is followed one cycle later by a sample strobe on each half's node and by a pixel-valid flag. All strobe outputs are registered, so they appear one cycle after the internal phase that produces them.

Top module: `ccd_readout_seq`

## Requirements
- R1: During reset and after it, before any start pulse, all strobe and marker outputs stay low.
- R2: The mode field uses these codes: 0 = timed exposure, 1 = continuous, 2 = flush, and 3 behaves as 0. A timed-exposure frame emits one frame marker cycle, followed directly by `rows` cycles in which the imaging and storage strobes are both high.
- R3: After the frame move, timed exposure issues `skip` storage-only shifts, clipped to `rows`. Only the remaining `rows - skip` rows are read. When the remainder is zero, the frame has no serial activity.
- R4: Each read group consists of N storage shifts followed by one row marker and one serial burst. N is `sum`, a `sum` of 0 acts as 1, and the final group of a frame is cut down to the rows left.
- R5: A serial burst lasts `cols/2` shift cycles. In the cycle after each shift, both node sample strobes and the pixel-valid flag are high.
- R6: Parallel and serial strobes are never high in the same cycle. After the last parallel strobe of a group come exactly IDLE_GAP idle cycles, then the row marker cycle, then the first serial shift.
- R7: In continuous mode, each group asserts the imaging and storage strobes together for N cycles and is followed by one read row. There is no frame marker, `skip` is ignored, and groups repeat until stopped.
- R8: In flush mode, the imaging strobe is high for `rows` cycles, while the storage and serial strobes stay low.
- R9: Mode and geometry are taken only at a frame or group boundary, and a start pulse while running has no effect.
- R10: A stop request ends operation after the current frame or group completes. After that, no strobe is issued until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start pulse, taken only when idle |
| stop_i | input | 1 | Stop request, honoured at the next boundary |
| mode_i | input | 2 | 0 timed exposure, 1 continuous, 2 flush, 3 as 0 |
| rows_i | input | ROW_W (11) | Rows per section (0 acts as 1) |
| cols_i | input | COL_W (11) | Columns per row, split over the two halves |
| skip_i | input | ROW_W (11) | Subarray rows dumped before readout |
| sum_i | input | ROW_W (11) | Rows summed per read row (0 acts as 1) |
| img_par_o | output | 1 | Imaging section parallel transfer strobe |
| fs_par_o | output | 1 | Storage section parallel transfer strobe |
| ser_shift_o | output | 1 | Serial register shift strobe, both halves |
| samp_a_o | output | 1 | Output node sample strobe, first half |
| samp_b_o | output | 1 | Output node sample strobe, second half |
| pix_valid_o | output | 1 | A sampled pixel pair is valid |
| row_start_o | output | 1 | Marker cycle before the first shift of a read row |
| frame_start_o | output | 1 | Marker at the start of each timed-exposure frame |

## Verification
Several properties are checked on every cycle:

- serial strobes never coincide with parallel strobes;
- a row marker is always followed by a shift, and a frame marker by a full transfer;
- the latched skip never exceeds the latched row count;
- the mode register changes only in the load step;
- entry into idle or into the load step happens only from an end-of-frame or end-of-group phase.

Other behaviour can only be shown by the bench's scenarios:

- the strobe counts that follow from each combination of rows, columns, skip and sum;
- the truncation of the last summing group;
- the exact idle gap;
- the fact that a mode change in mid-group waits for the boundary;
- the absence of activity after a stop.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [1:0] {
    MODE_TIMED = 2'd0,
    MODE_CONT  = 2'd1,
    MODE_FLUSH = 2'd2
  } mode_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOAD,
    ST_FMARK,
    ST_XFER,
    ST_SKIP,
    ST_PAR,
    ST_GAP,
    ST_RMARK,
    ST_SHIFT
  } state_e;

endpackage

// File: rtl/ccd_seq_cfg.sv
module ccd_seq_cfg
  import ccd_seq_pkg::*;
#(
  parameter int ROW_W = 11,
  parameter int COL_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [1:0]       mode_i,
  input  logic [ROW_W-1:0] rows_i,
  input  logic [COL_W-1:0] cols_i,
  input  logic [ROW_W-1:0] skip_i,
  input  logic [ROW_W-1:0] sum_i,
  output mode_e            mode_d_o,
  output logic [ROW_W-1:0] rows_d_o,
  output logic [ROW_W-1:0] sum_d_o,
  output mode_e            mode_q_o,
  output logic [ROW_W-1:0] rows_q_o,
  output logic [COL_W-1:0] half_q_o,
  output logic [ROW_W-1:0] skip_q_o,
  output logic [ROW_W-1:0] sum_q_o
);

  logic [COL_W-1:0] half_d;
  logic [ROW_W-1:0] skip_d;

  // sanitise raw inputs before they are latched
  always_comb begin
    case (mode_i)
      2'd1:    mode_d_o = MODE_CONT;
      2'd2:    mode_d_o = MODE_FLUSH;
      default: mode_d_o = MODE_TIMED;
    endcase
    rows_d_o = (rows_i == '0) ? ROW_W'(1) : rows_i;
    sum_d_o  = (sum_i == '0) ? ROW_W'(1) : sum_i;
    half_d   = (cols_i[COL_W-1:1] == '0) ? COL_W'(1) : (cols_i >> 1);
    skip_d   = (skip_i > rows_d_o) ? rows_d_o : skip_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q_o <= MODE_TIMED;
      rows_q_o <= ROW_W'(1);
      half_q_o <= COL_W'(1);
      skip_q_o <= '0;
      sum_q_o  <= ROW_W'(1);
    end else if (load_i) begin
      mode_q_o <= mode_d_o;
      rows_q_o <= rows_d_o;
      half_q_o <= half_d;
      skip_q_o <= skip_d;
      sum_q_o  <= sum_d_o;
    end
  end

  AST_SKIP_CLIPPED: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q_o <= rows_q_o); // R3
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(mode_q_o)); // R9

endmodule

// File: rtl/ccd_seq_fsm.sv
module ccd_seq_fsm
  import ccd_seq_pkg::*;
#(
  parameter int ROW_W    = 11,
  parameter int COL_W    = 11,
  parameter int IDLE_GAP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  mode_e            mode_d_i,
  input  logic [ROW_W-1:0] rows_d_i,
  input  logic [ROW_W-1:0] sum_d_i,
  input  mode_e            mode_q_i,
  input  logic [ROW_W-1:0] rows_q_i,
  input  logic [COL_W-1:0] half_q_i,
  input  logic [ROW_W-1:0] skip_q_i,
  input  logic [ROW_W-1:0] sum_q_i,
  output state_e           state_o,
  output logic             load_o
);

  localparam int GAP_W = $clog2(IDLE_GAP + 2);
  localparam int CNT_A = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int CNT_W = (CNT_A > GAP_W) ? CNT_A : GAP_W;

  state_e           st, st_n;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [ROW_W-1:0] rem, rem_n;
  logic             stop_pend, stop_pend_n;
  logic             boundary, enter_read, last;
  logic [ROW_W-1:0] read_rows, grp;

  assign last = (cnt == CNT_W'(1));

  always_comb begin
    st_n       = st;
    cnt_n      = cnt;
    rem_n      = rem;
    boundary   = 1'b0;
    enter_read = 1'b0;
    read_rows  = '0;
    grp        = '0;
    case (st)
      ST_IDLE: if (start_i) st_n = ST_LOAD;
      ST_LOAD: begin
        case (mode_d_i)
          MODE_FLUSH: begin
            st_n  = ST_XFER;
            cnt_n = CNT_W'(rows_d_i);
          end
          MODE_CONT: begin
            st_n  = ST_PAR;
            cnt_n = CNT_W'(sum_d_i);
            rem_n = '0;
          end
          default: st_n = ST_FMARK;
        endcase
      end
      ST_FMARK: begin
        st_n  = ST_XFER;
        cnt_n = CNT_W'(rows_q_i);
      end
      ST_XFER: begin
        if (!last) cnt_n = cnt - CNT_W'(1);
        else if (mode_q_i == MODE_FLUSH) boundary = 1'b1;
        else if (skip_q_i != '0) begin
          st_n  = ST_SKIP;
          cnt_n = CNT_W'(skip_q_i);
        end else begin
          enter_read = 1'b1;
          read_rows  = rows_q_i;
        end
      end
      ST_SKIP: begin
        if (!last) cnt_n = cnt - CNT_W'(1);
        else begin
          enter_read = 1'b1;
          read_rows  = rows_q_i - skip_q_i;
        end
      end
      ST_PAR: begin
        if (!last) cnt_n = cnt - CNT_W'(1);
        else if (IDLE_GAP == 0) st_n = ST_RMARK;
        else begin
          st_n  = ST_GAP;
          cnt_n = CNT_W'(IDLE_GAP);
        end
      end
      ST_GAP: begin
        if (!last) cnt_n = cnt - CNT_W'(1);
        else st_n = ST_RMARK;
      end
      ST_RMARK: begin
        st_n  = ST_SHIFT;
        cnt_n = CNT_W'(half_q_i);
      end
      ST_SHIFT: begin
        if (!last) cnt_n = cnt - CNT_W'(1);
        else if (mode_q_i == MODE_TIMED && rem != '0) begin
          enter_read = 1'b1;
          read_rows  = rem;
        end else boundary = 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase

    if (enter_read) begin
      if (read_rows == '0) boundary = 1'b1;
      else begin
        grp   = (sum_q_i < read_rows) ? sum_q_i : read_rows;
        st_n  = ST_PAR;
        cnt_n = CNT_W'(grp);
        rem_n = read_rows - grp;
      end
    end

    if (boundary) st_n = (stop_pend || stop_i) ? ST_IDLE : ST_LOAD;

    stop_pend_n = (st_n == ST_IDLE) ? 1'b0 : (stop_pend || stop_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      rem       <= '0;
      stop_pend <= 1'b0;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      rem       <= rem_n;
      stop_pend <= stop_pend_n;
    end
  end

  assign state_o = st;
  assign load_o  = (st == ST_LOAD);

  AST_LOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_LOAD) |-> $past(st == ST_IDLE || st == ST_XFER || st == ST_SKIP || st == ST_SHIFT)); // R9
  AST_STOP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && $past(st) != ST_IDLE) |-> $past(st == ST_XFER || st == ST_SKIP || st == ST_SHIFT)); // R10
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SHIFT) |-> (rem <= rows_q_i)); // R3

endmodule

// File: rtl/ccd_seq_out.sv
module ccd_seq_out
  import ccd_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  state_e state_i,
  input  mode_e  mode_i,
  output logic   img_par_o,
  output logic   fs_par_o,
  output logic   ser_shift_o,
  output logic   samp_a_o,
  output logic   samp_b_o,
  output logic   pix_valid_o,
  output logic   row_start_o,
  output logic   frame_start_o
);

  logic img_n, fs_n, ser_n, row_n, frm_n;

  always_comb begin
    img_n = (state_i == ST_XFER) || (state_i == ST_PAR && mode_i == MODE_CONT);
    fs_n  = (state_i == ST_XFER && mode_i != MODE_FLUSH) ||
            (state_i == ST_SKIP) || (state_i == ST_PAR);
    ser_n = (state_i == ST_SHIFT);
    row_n = (state_i == ST_RMARK);
    frm_n = (state_i == ST_FMARK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      img_par_o     <= 1'b0;
      fs_par_o      <= 1'b0;
      ser_shift_o   <= 1'b0;
      row_start_o   <= 1'b0;
      frame_start_o <= 1'b0;
      samp_a_o      <= 1'b0;
      samp_b_o      <= 1'b0;
      pix_valid_o   <= 1'b0;
    end else begin
      img_par_o     <= img_n;
      fs_par_o      <= fs_n;
      ser_shift_o   <= ser_n;
      row_start_o   <= row_n;
      frame_start_o <= frm_n;
      samp_a_o      <= ser_shift_o;
      samp_b_o      <= ser_shift_o;
      pix_valid_o   <= ser_shift_o;
    end
  end

  AST_NO_PAR_SER: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_shift_o && (img_par_o || fs_par_o))); // R6
  AST_MARK_THEN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    row_start_o |=> ser_shift_o); // R6
  AST_FRAME_THEN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_o |=> (img_par_o && fs_par_o)); // R2

endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq
  import ccd_seq_pkg::*;
#(
  parameter int MAX_ROWS = 1026,
  parameter int MAX_COLS = 1024,
  parameter int IDLE_GAP = 2,
  localparam int ROW_W = $clog2(MAX_ROWS + 1),
  localparam int COL_W = $clog2(MAX_COLS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [1:0]       mode_i,
  input  logic [ROW_W-1:0] rows_i,
  input  logic [COL_W-1:0] cols_i,
  input  logic [ROW_W-1:0] skip_i,
  input  logic [ROW_W-1:0] sum_i,
  output logic             img_par_o,
  output logic             fs_par_o,
  output logic             ser_shift_o,
  output logic             samp_a_o,
  output logic             samp_b_o,
  output logic             pix_valid_o,
  output logic             row_start_o,
  output logic             frame_start_o
);

  mode_e            mode_d, mode_q;
  logic [ROW_W-1:0] rows_d, sum_d, rows_q, skip_q, sum_q;
  logic [COL_W-1:0] half_q;
  logic             load;
  state_e           state;

  ccd_seq_cfg #(.ROW_W(ROW_W), .COL_W(COL_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (load),
    .mode_i   (mode_i),
    .rows_i   (rows_i),
    .cols_i   (cols_i),
    .skip_i   (skip_i),
    .sum_i    (sum_i),
    .mode_d_o (mode_d),
    .rows_d_o (rows_d),
    .sum_d_o  (sum_d),
    .mode_q_o (mode_q),
    .rows_q_o (rows_q),
    .half_q_o (half_q),
    .skip_q_o (skip_q),
    .sum_q_o  (sum_q)
  );

  ccd_seq_fsm #(.ROW_W(ROW_W), .COL_W(COL_W), .IDLE_GAP(IDLE_GAP)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .stop_i   (stop_i),
    .mode_d_i (mode_d),
    .rows_d_i (rows_d),
    .sum_d_i  (sum_d),
    .mode_q_i (mode_q),
    .rows_q_i (rows_q),
    .half_q_i (half_q),
    .skip_q_i (skip_q),
    .sum_q_i  (sum_q),
    .state_o  (state),
    .load_o   (load)
  );

  ccd_seq_out u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .state_i       (state),
    .mode_i        (mode_q),
    .img_par_o     (img_par_o),
    .fs_par_o      (fs_par_o),
    .ser_shift_o   (ser_shift_o),
    .samp_a_o      (samp_a_o),
    .samp_b_o      (samp_b_o),
    .pix_valid_o   (pix_valid_o),
    .row_start_o   (row_start_o),
    .frame_start_o (frame_start_o)
  );

endmodule

// File: tb/test_ccd_readout_seq.sv
module test_ccd_readout_seq;

  localparam int GAP = 2;

  logic        clk, rst_n, start, stop;
  logic [1:0]  mode;
  logic [10:0] rows, cols, skip, sum;
  logic img, fs, ser, sa, sb, pv, rowm, frm;

  ccd_readout_seq #(.MAX_ROWS(1026), .MAX_COLS(1024), .IDLE_GAP(GAP)) i_ccd_readout_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .stop_i(stop), .mode_i(mode),
    .rows_i(rows), .cols_i(cols), .skip_i(skip), .sum_i(sum),
    .img_par_o(img), .fs_par_o(fs), .ser_shift_o(ser), .samp_a_o(sa), .samp_b_o(sb),
    .pix_valid_o(pv), .row_start_o(rowm), .frame_start_o(frm)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [1:0]  m;
    logic [10:0] r, c, s, n;
    logic [15:0] e_img, e_fs, e_ser, e_row, e_frm;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{2'd0, 11'd6, 11'd4, 11'd0, 11'd1, 16'd6, 16'd12, 16'd12, 16'd6, 16'd1},
    '{2'd0, 11'd6, 11'd4, 11'd2, 11'd1, 16'd6, 16'd12, 16'd8,  16'd4, 16'd1},
    '{2'd0, 11'd6, 11'd4, 11'd0, 11'd2, 16'd6, 16'd12, 16'd6,  16'd3, 16'd1},
    '{2'd0, 11'd7, 11'd6, 11'd1, 11'd4, 16'd7, 16'd14, 16'd6,  16'd2, 16'd1},
    '{2'd0, 11'd5, 11'd4, 11'd5, 11'd1, 16'd5, 16'd10, 16'd0,  16'd0, 16'd1},
    '{2'd0, 11'd5, 11'd4, 11'd9, 11'd1, 16'd5, 16'd10, 16'd0,  16'd0, 16'd1},
    '{2'd1, 11'd6, 11'd4, 11'd0, 11'd1, 16'd1, 16'd1,  16'd2,  16'd1, 16'd0},
    '{2'd1, 11'd6, 11'd4, 11'd2, 11'd3, 16'd3, 16'd3,  16'd2,  16'd1, 16'd0},
    '{2'd2, 11'd6, 11'd4, 11'd0, 11'd1, 16'd6, 16'd0,  16'd0,  16'd0, 16'd0},
    '{2'd0, 11'd4, 11'd2, 11'd0, 11'd0, 16'd4, 16'd8,  16'd4,  16'd4, 16'd1},
    '{2'd3, 11'd3, 11'd2, 11'd0, 11'd1, 16'd3, 16'd6,  16'd3,  16'd3, 16'd1},
    '{2'd0, 11'd4, 11'd2, 11'd0, 11'd9, 16'd4, 16'd8,  16'd1,  16'd1, 16'd1}
  };

  int total, fails;
  int n_img, n_fs, n_ser, n_sa, n_sb, n_pv, n_row, n_frm;
  int cyc, last_par, ovl_err, gap_err, ord_err, img_at_frame;
  logic prev_ser, prev_row, seen_frame;

  // passive monitor away from the active edge
  initial begin
    cyc = 0; last_par = 0; ovl_err = 0; gap_err = 0; ord_err = 0;
    prev_ser = 1'b0; prev_row = 1'b0; seen_frame = 1'b0; img_at_frame = 0;
    n_img = 0; n_fs = 0; n_ser = 0; n_sa = 0; n_sb = 0; n_pv = 0; n_row = 0; n_frm = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (img) n_img++;
      if (fs) n_fs++;
      if (ser) n_ser++;
      if (sa) n_sa++;
      if (sb) n_sb++;
      if (pv) n_pv++;
      if (rowm) n_row++;
      if (frm) begin
        n_frm++;
        if (!seen_frame) begin seen_frame = 1'b1; img_at_frame = n_img; end
      end
      if (ser && (img || fs)) ovl_err++;
      if (img || fs) last_par = cyc;
      if (rowm && (cyc - last_par != GAP + 1)) gap_err++;
      if (ser && !prev_ser && !prev_row) ord_err++;
      prev_ser = ser;
      prev_row = rowm;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clr();
    n_img = 0; n_fs = 0; n_ser = 0; n_sa = 0; n_sb = 0; n_pv = 0; n_row = 0; n_frm = 0;
    seen_frame = 1'b0; img_at_frame = 0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", total, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    total = 0; fails = 0;
    rst_n = 1'b0; start = 1'b0; stop = 1'b0;
    mode = 2'd0; rows = 11'd6; cols = 11'd4; skip = '0; sum = 11'd1;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1 strobes in reset", int'({img, fs, ser, sa, sb, pv, rowm, frm}), 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 no activity before start", n_img + n_fs + n_ser + n_row + n_frm + n_pv, 0);

    // table walk: single frame or group per vector, stop queued right after start
    for (int i = 0; i < 12; i++) begin
      clr();
      mode = VECS[i].m; rows = VECS[i].r; cols = VECS[i].c;
      skip = VECS[i].s; sum = VECS[i].n;
      start = 1'b1;
      @(negedge clk); start = 1'b0; stop = 1'b1;
      @(negedge clk); stop = 1'b0;
      repeat (300) @(negedge clk);
      $display("vector %0d", i);
      chk("R2 R7 R8 imaging strobes", n_img, int'(VECS[i].e_img));
      chk("R3 R4 storage strobes", n_fs, int'(VECS[i].e_fs));
      chk("R5 serial shifts", n_ser, int'(VECS[i].e_ser));
      chk("R4 row markers", n_row, int'(VECS[i].e_row));
      chk("R2 frame markers", n_frm, int'(VECS[i].e_frm));
      chk("R5 node A samples", n_sa, int'(VECS[i].e_ser));
      chk("R5 node B samples", n_sb, int'(VECS[i].e_ser));
      chk("R5 pixel valid", n_pv, int'(VECS[i].e_ser));
    end

    // R9: mode change in mid-group waits; start while busy ignored
    clr();
    mode = 2'd1; rows = 11'd6; cols = 11'd4; skip = '0; sum = 11'd1;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (3) @(negedge clk);
    mode = 2'd0;
    while (!seen_frame) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0; stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    repeat (300) @(negedge clk);
    chk("R9 continuous group before switch", img_at_frame, 1);
    chk("R9 imaging total", n_img, 7);
    chk("R9 storage total", n_fs, 13);
    chk("R9 row markers total", n_row, 7);
    chk("R9 single frame", n_frm, 1);

    // R7 R10: continuous repeats until stop, then quiet
    clr();
    mode = 2'd1; sum = 11'd2; skip = 11'd3;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (100) @(negedge clk);
    stop = 1'b1;
    @(negedge clk); stop = 1'b0;
    repeat (50) @(negedge clk);
    chk("R7 repeated groups", int'(n_row >= 5), 1);
    chk("R7 imaging per group", n_img, 2 * n_row);
    chk("R7 storage per group", n_fs, 2 * n_row);
    chk("R7 shifts per group", n_ser, 2 * n_row);
    chk("R7 no frame marker", n_frm, 0);
    clr();
    repeat (100) @(negedge clk);
    chk("R10 quiet after stop", n_img + n_fs + n_ser + n_row + n_pv, 0);

    // R6: global monitors
    chk("R6 parallel and serial overlap", ovl_err, 0);
    chk("R6 idle gap length", gap_err, 0);
    chk("R6 marker before shift", ord_err, 0);

    summary();
    $finish;
  end

endmodule